// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Control

This block is a general-purpose I/O port of up to eight pins behind a small synchronous register bus. Software writes an output value register and a per-pin direction register. It reads back the pin levels, which pass through a two-stage synchronizer, rather than the stored output value. Each pin drives a pad model through three signals: an output value, an output enable and a sampled input.

Two kinds of override sit between the registers and the pads. An analog-select register covers the pins that can carry analog signals. An analog-selected pin always reads as zero on the data register, although it can still be driven. Peripheral-select inputs, one per pin, hand both the driven value and the output enable of a pin to an on-chip peripheral. One pin chosen by parameter is open-drain. It can only pull low or release.

The register width and the number of implemented pins are parameters. Register bits above the last implemented pin read as zero.

Top module: `gpio_port`

## Requirements
- R1: With peripheral select low, a direction bit of 1 sets `pad_oe` low for that pin. A direction bit of 0 sets `pad_oe` high, and a push-pull pin then drives its output-latch bit on `pad_out`.
- R2: Reading address 0 returns the levels on `pad_in`, not the output latch, in both directions. A change on `pad_in` first shows on `bus_rdata` after the second rising clock edge.
- R3: A write to address 0 changes only the output latch, whatever the direction bits are. A value written while every pin is an input appears on the pads once the direction bits are cleared.
- R4: A pin whose analog-select bit is 1 reads as 0 at address 0, even while it is driven as an output. Only the analog-capable pins in `ANALOG_MASK` (default pins 0 to 3) keep a written 1 in the analog-select register at address 2.
- R5: While `periph_sel[i]` is 1, pin i drives `periph_dout[i]` and uses `periph_oe[i]` as its enable. While `periph_sel[i]` is 0, `periph_oe[i]` and `periph_dout[i]` have no effect.
- R6: The open-drain pin (`OD_PIN`, default 4) never drives high: `pad_out` is 0 there. Its `pad_oe` is 1 only when the pin is enabled to drive and the selected data bit is 0.
- R7: After reset, the direction register reads all implemented bits 1 (0x3F by default), the analog register reads `ANALOG_MASK` (0x0F), and `pad_oe` is all zero.
- R8: Register bits at positions `PIN_N` and above (bits 7:6 by default) read as 0 at addresses 0, 1 and 2, whatever was written.
- R9: Address map: 0 is data, 1 is direction, 2 is analog select. Address 3 reads 0, and writes to it change no register.
- R10: `bus_rdata` follows `bus_addr` combinationally. A register written at one rising edge reads back its new value straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data for `bus_addr` |
| periph_sel | input | PIN_N | Per-pin hand-over to a peripheral |
| periph_dout | input | PIN_N | Peripheral output data |
| periph_oe | input | PIN_N | Peripheral output enable |
| pad_in | input | PIN_N | Level seen at each pad |
| pad_out | output | PIN_N | Value driven to each pad |
| pad_oe | output | PIN_N | Drive enable for each pad |

## Verification
The hardest case to reach from the ports is a pin whose read-back differs from what software last wrote. This happens on a driven pin that is analog-selected, on a pin taken over by a peripheral, and on the open-drain pin released against an external low. The bench models the pads with a per-pin external level that applies whenever `pad_oe` is low. Random rounds then draw the latch, direction, analog, peripheral and external levels together, so these mixed cases occur often. Directed sequences cover the latch written before the direction is cleared, the two-edge synchronizer delay, and the unused address.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_ANA  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_rst_sync.sv
module gpio_port_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_port_in_sync.sv
module gpio_port_in_sync #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int               REG_W       = 8,
  parameter int               PIN_N       = 6,
  parameter logic [PIN_N-1:0] ANALOG_MASK = 6'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [PIN_N-1:0]  pin_sync,
  output logic [REG_W-1:0]  rdata,
  output logic [PIN_N-1:0]  latch_q,
  output logic [PIN_N-1:0]  dir_q,
  output logic [PIN_N-1:0]  ana_q
);
  reg_sel_e         sel;
  logic             latch_en, dir_en, ana_en;
  logic [PIN_N-1:0] latch_d, dir_d, ana_d;
  logic [PIN_N-1:0] rd_pins;

  // next-state
  always_comb begin
    sel      = reg_sel_e'(addr);
    latch_en = wr && (sel == SEL_DATA);
    dir_en   = wr && (sel == SEL_DIR);
    ana_en   = wr && (sel == SEL_ANA);
    latch_d  = wdata[PIN_N-1:0];
    dir_d    = wdata[PIN_N-1:0];
    ana_d    = wdata[PIN_N-1:0] & ANALOG_MASK;
  end

  // output latch: no reset value
  always_ff @(posedge clk) begin
    if (latch_en) latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '1;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ana_q <= ANALOG_MASK;
    else if (ana_en) ana_q <= ana_d;
  end

  // read mux
  always_comb begin
    unique case (sel)
      SEL_DATA: rd_pins = pin_sync & ~ana_q;
      SEL_DIR:  rd_pins = dir_q;
      SEL_ANA:  rd_pins = ana_q;
      default:  rd_pins = '0;
    endcase
    rdata = REG_W'(rd_pins);
  end

  p_dir_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == SEL_DIR) |=> (dir_q == $past(wdata[PIN_N-1:0])));

  p_ana_capable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ana_q & ~ANALOG_MASK) == '0));

  p_ana_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == SEL_DATA && ana_q[0]) |-> !rdata[0]);

  p_none_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == SEL_NONE) |-> (rdata == '0));

  generate
    if (REG_W > PIN_N) begin : g_upper
      p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[REG_W-1:PIN_N] == '0));
    end
  endgenerate
endmodule

// File: rtl/gpio_port_pad_ctrl.sv
module gpio_port_pad_ctrl #(
  parameter int PIN_N  = 6,
  parameter int OD_PIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_N-1:0] latch_q,
  input  logic [PIN_N-1:0] dir_q,
  input  logic [PIN_N-1:0] periph_sel,
  input  logic [PIN_N-1:0] periph_dout,
  input  logic [PIN_N-1:0] periph_oe,
  output logic [PIN_N-1:0] pad_out,
  output logic [PIN_N-1:0] pad_oe
);
  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    logic src_val;
    logic src_en;

    always_comb begin
      src_val = periph_sel[i] ? periph_dout[i] : latch_q[i];
      src_en  = periph_sel[i] ? periph_oe[i]   : !dir_q[i];
    end

    if (i == OD_PIN) begin : g_open_drain
      always_comb begin
        pad_out[i] = 1'b0;
        pad_oe[i]  = src_en && !src_val;
      end

      p_od_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_sel[i] && latch_q[i]) |-> !pad_oe[i]);
    end else begin : g_push_pull
      always_comb begin
        pad_out[i] = src_val;
        pad_oe[i]  = src_en;
      end

      p_input_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_sel[i] && dir_q[i]) |-> !pad_oe[i]);

      p_periph_oe_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_sel[i] && !dir_q[i]) |-> (pad_oe[i] && pad_out[i] == latch_q[i]));
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int               REG_W       = 8,
  parameter int               PIN_N       = 6,
  parameter int               OD_PIN      = 4,
  parameter logic [PIN_N-1:0] ANALOG_MASK = 6'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [PIN_N-1:0]  periph_sel,
  input  logic [PIN_N-1:0]  periph_dout,
  input  logic [PIN_N-1:0]  periph_oe,
  input  logic [PIN_N-1:0]  pad_in,
  output logic [PIN_N-1:0]  pad_out,
  output logic [PIN_N-1:0]  pad_oe
);
  logic             rst_n_sync;
  logic [PIN_N-1:0] pin_sync;
  logic [PIN_N-1:0] latch_q, dir_q, ana_q;

  gpio_port_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  gpio_port_in_sync #(.WIDTH(PIN_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_port_regs #(
    .REG_W       (REG_W),
    .PIN_N       (PIN_N),
    .ANALOG_MASK (ANALOG_MASK)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .ana_q    (ana_q)
  );

  gpio_port_pad_ctrl #(
    .PIN_N  (PIN_N),
    .OD_PIN (OD_PIN)
  ) u_pads (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .latch_q     (latch_q),
    .dir_q       (dir_q),
    .periph_sel  (periph_sel),
    .periph_dout (periph_dout),
    .periph_oe   (periph_oe),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe)
  );
endmodule

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  localparam int          REG_W  = 8;
  localparam int          PIN_N  = 6;
  localparam int          OD     = 4;
  localparam logic [5:0]  AMASK  = 6'h0F;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bus_wr;
  logic [1:0]       bus_addr;
  logic [REG_W-1:0] bus_wdata;
  logic [REG_W-1:0] bus_rdata;
  logic [PIN_N-1:0] periph_sel, periph_dout, periph_oe;
  logic [PIN_N-1:0] pad_in, pad_out, pad_oe;
  logic [PIN_N-1:0] ext;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [5:0] m_latch, m_dir, m_ana;

  always #2 clk = ~clk;

  // pad model: driven pins see the driven value, released pins the external level
  for (genvar i = 0; i < PIN_N; i++) begin : g_padm
    assign pad_in[i] = pad_oe[i] ? pad_out[i] : ext[i];
  end

  gpio_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_sel(periph_sel),
    .periph_dout(periph_dout), .periph_oe(periph_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [5:0] f_oe();
    logic [5:0] r;
    for (int i = 0; i < PIN_N; i++) begin
      logic d, e;
      d = periph_sel[i] ? periph_dout[i] : m_latch[i];
      e = periph_sel[i] ? periph_oe[i]   : !m_dir[i];
      r[i] = (i == OD) ? (e && !d) : e;
    end
    return r;
  endfunction

  function automatic logic [5:0] f_out();
    logic [5:0] r;
    for (int i = 0; i < PIN_N; i++) begin
      logic d;
      d = periph_sel[i] ? periph_dout[i] : m_latch[i];
      r[i] = (i == OD) ? 1'b0 : d;
    end
    return r;
  endfunction

  function automatic logic [7:0] f_rd();
    logic [5:0] oe, lv;
    oe = f_oe();
    lv = (oe & f_out()) | (~oe & ext);
    return {2'b00, lv & ~m_ana};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
    if (a == 2'd0) m_latch = d[5:0];
    if (a == 2'd1) m_dir   = d[5:0];
    if (a == 2'd2) m_ana   = d[5:0] & AMASK;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #0.2; d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    periph_sel = '0; periph_dout = '0; periph_oe = '0; ext = '0;
    m_latch = '0; m_dir = '1; m_ana = AMASK;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R7 reset state
    rd(2'd1, v); chk("R7 dir reset", v, 8'h3F);
    rd(2'd2, v); chk("R7 ana reset", v, 8'h0F);
    chk("R7 pad_oe reset", pad_oe, 6'h00);

    // R3: latch written while all inputs, then direction cleared
    wr(2'd2, 8'h00);
    ext = 6'h15;
    wr(2'd0, 8'h2A);
    repeat (3) tick();
    chk("R3 latch write keeps pads released", pad_oe, 6'h00);
    rd(2'd0, v); chk("R2 read returns pins not latch", v, 8'h15);
    wr(2'd1, 8'h00);
    chk("R3 latch appears on pads", pad_out, f_out());
    chk("R1 cleared dir enables drive", pad_oe, f_oe());
    chk("R6 open-drain pulls low for 0", pad_oe[OD], 1'b1);

    // R6 open-drain release with external low
    wr(2'd0, 8'h3F); ext = 6'h00;
    repeat (3) tick();
    chk("R6 open-drain releases for 1", pad_oe[OD], 1'b0);
    chk("R6 open-drain never high", pad_out[OD], 1'b0);
    rd(2'd0, v); chk("R2 released OD pin reads external low", v, f_rd());

    // R4 analog pins read zero while driven
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R4 only capable pins keep analog", v, 8'h0F);
    repeat (3) tick();
    rd(2'd0, v); chk("R4 driven analog pins read zero", v, 8'h20);
    wr(2'd2, 8'h00);

    // R8 upper bits
    wr(2'd1, 8'hC0);
    rd(2'd1, v); chk("R8 dir upper bits zero", v, 8'h00);
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R8 data upper bits zero", v[7:6], 2'b00);

    // R9 unused address
    wr(2'd1, 8'h12);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R9 addr3 reads zero", v, 8'h00);
    rd(2'd1, v); chk("R9 addr3 write ignored dir", v, 8'h12);
    rd(2'd2, v); chk("R9 addr3 write ignored ana", v, 8'h00);

    // R10 write visible straight after edge
    wr(2'd1, 8'h2D);
    rd(2'd1, v); chk("R10 dir readback next cycle", v, 8'h2D);

    // R2 synchronizer latency
    wr(2'd1, 8'h3F);
    ext = 6'h00; repeat (3) tick();
    ext = 6'h21;
    tick();
    rd(2'd0, v); chk("R2 not visible after one edge", v, 8'h00);
    tick();
    rd(2'd0, v); chk("R2 visible after two edges", v, 8'h21);

    // R5 peripheral override and gating
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    periph_sel = 6'h00; periph_oe = 6'h00; periph_dout = 6'h3F;
    tick();
    chk("R5 periph ignored when not selected oe", pad_oe, 6'h3F);
    chk("R5 periph ignored when not selected out", pad_out, 6'h00);
    periph_sel = 6'h03; periph_oe = 6'h01;
    tick();
    chk("R5 periph overrides oe", pad_oe, f_oe());
    chk("R5 periph overrides data", pad_out, f_out());
    periph_sel = '0; periph_oe = '0; periph_dout = '0;

    // random rounds
    for (int n = 0; n < 300; n++) begin
      wr(2'd0, 8'($urandom));
      wr(2'd1, 8'($urandom));
      wr(2'd2, 8'($urandom));
      periph_sel  = 6'($urandom) & 6'($urandom);
      periph_dout = 6'($urandom);
      periph_oe   = 6'($urandom);
      ext         = 6'($urandom);
      repeat (3) tick();
      chk("R1 R5 R6 random pad_oe", pad_oe, f_oe());
      chk("R1 R5 R6 random pad_out", pad_out, f_out());
      rd(2'd0, v); chk("R2 R4 random read", v, f_rd());
      rd(2'd1, v); chk("R8 random dir read", v, {2'b00, m_dir});
      rd(2'd2, v); chk("R4 random ana read", v, {2'b00, m_ana});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule